// File: doc/BRIEF.md
# Low-Power Sleep Mode Controller

This block sequences the power modes of a small processor core around a sleep state. When the core executes its sleep instruction and the standby-select bit is clear, the block takes away the core's clock enable. The core then stops fetching but keeps every internal register. Peripheral clocks are not touched by this block and keep running.

Three events end sleep, and each has its own outcome. A qualified interrupt returns the core to run and starts interrupt exception processing. A qualified interrupt is either an enabled request that the CPU mask does not block, or the non-maskable interrupt. A reset pin held low long enough places the core in a reset hold, and releasing the pin starts reset exception processing. A low standby pin moves the block straight into hardware standby. Only a qualified reset leaves hardware standby.

The minimum reset-low time is a parameter counted in clock cycles. A shorter low pulse on the reset pin is ignored. When several wake events arrive in the same cycle, reset wins over standby, and standby wins over interrupts.

Top module: `slumber_ctrl`

## Requirements
- R1: A sleep strobe moves the block from run to sleep only while `sby_sel` is 0, and `cpu_run` reads 0 from the next cycle. A strobe while `sby_sel` is 1 has no effect and `cpu_run` stays 1.
- R2: While sleeping, `cpu_run` stays 0. A request line whose enable bit is 0 does not end sleep.
- R3: In sleep, a request with its enable bit at 1 and `mask_all` at 0 ends sleep. In the next cycle `cpu_run` is 1 and `irq_exc_go` is 1, in the same cycle.
- R4: While `mask_all` is 1, enabled requests do not end sleep. Only `nmi` wakes the core, with the same outcome as R3.
- R5: A low `sby_pin_n` during sleep sets `hw_standby` to 1 and holds `cpu_run` at 0 from the next cycle. Hardware standby persists after the pin returns high and ends only by R6. A low `sby_pin_n` while running has no effect.
- R6: From any state, once `rst_pin_n` has been sampled low for MIN_RST_LOW consecutive cycles, the block enters reset hold from the next cycle. In reset hold `cpu_run` is 0 and `hw_standby` is 0 for as long as the pin stays low.
- R7: After reset hold, the first cycle in which `rst_pin_n` is sampled high gives, in the following cycle, `rst_exc_go` at 1 and `cpu_run` at 1.
- R8: A low pulse on `rst_pin_n` shorter than MIN_RST_LOW cycles is ignored. No output changes and no reset pulse follows.
- R9: In one cycle, a qualifying reset beats a low standby pin, and a low standby pin beats any waking interrupt.
- R10: `irq_exc_go` and `rst_exc_go` are single-cycle pulses. After power-on reset, `cpu_run` is 1 and the other outputs are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| por_n | input | 1 | Asynchronous power-on reset, active low |
| sleep_op | input | 1 | One-cycle strobe: core executed its sleep instruction |
| sby_sel | input | 1 | Standby-select bit; sleep is entered only when 0 |
| irq_req | input | N_IRQ | Interrupt request lines |
| irq_en | input | N_IRQ | Per-line enable bits |
| mask_all | input | 1 | CPU mask: blocks every request except nmi |
| nmi | input | 1 | Non-maskable interrupt |
| rst_pin_n | input | 1 | External reset pin, active low |
| sby_pin_n | input | 1 | External standby pin, active low |
| cpu_run | output | 1 | Core clock enable; 0 halts the core |
| irq_exc_go | output | 1 | Pulse: start interrupt exception processing |
| rst_exc_go | output | 1 | Pulse: start reset exception processing |
| hw_standby | output | 1 | Block is in hardware standby |

## Verification
Every result of this block is due exactly one clock edge after the stimulus that causes it. Sleep entry, interrupt wake, standby entry, reset-hold entry and the reset release pulse each appear in the cycle right after the sampling edge. The one exception is reset qualification, which first needs MIN_RST_LOW consecutive low samples. The bench drives inputs on the falling edge and files the expected output tuple for the coming rising edge into a queue. A monitor pops that entry shortly after the rising edge, so every comparison lands in the one cycle where the result is due. The reset-count corner is covered both one sample short of the limit and exactly at it.

// File: rtl/slumber_pkg.sv
package slumber_pkg;

    typedef enum logic [1:0] {
        PM_RUN   = 2'd0,
        PM_SLEEP = 2'd1,
        PM_RHOLD = 2'd2,
        PM_HSTBY = 2'd3
    } pm_state_e;

    typedef struct packed {
        pm_state_e st;
        logic      irq_go;
        logic      rst_go;
    } pm_regs_t;

endpackage

// File: rtl/slumber_wake_eval.sv
module slumber_wake_eval #(
    parameter int N_IRQ = 4
) (
    input  logic [N_IRQ-1:0] irq_req,
    input  logic [N_IRQ-1:0] irq_en,
    input  logic             mask_all,
    input  logic             nmi,
    output logic             wake
);
    logic [N_IRQ-1:0] line_live;

    for (genvar i = 0; i < N_IRQ; i++) begin : g_line
        assign line_live[i] = irq_req[i] & irq_en[i];
    end

    always_comb begin
        wake = nmi | ((|line_live) & ~mask_all);
    end

    always_comb begin
        if (mask_all && !nmi) begin
            a_r4_mask_blocks: assert (!wake);
        end
    end
endmodule

// File: rtl/slumber_rst_qual.sv
module slumber_rst_qual #(
    parameter int MIN_RST_LOW = 4
) (
    input  logic clk,
    input  logic por_n,
    input  logic rst_pin_n,
    output logic rst_fire
);
    localparam int CW = (MIN_RST_LOW < 2) ? 1 : $clog2(MIN_RST_LOW);
    localparam logic [CW-1:0] CNT_TOP = CW'(MIN_RST_LOW - 1);

    logic [CW-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d    = cnt_q;
        rst_fire = 1'b0;
        if (rst_pin_n) begin
            cnt_d = '0;
        end else if (cnt_q == CNT_TOP) begin
            rst_fire = 1'b1;
        end else begin
            cnt_d = cnt_q + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge por_n) begin
        if (!por_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    a_r8_fire_needs_low: assert property (@(posedge clk) disable iff (!por_n)
        rst_fire |-> !rst_pin_n);
    a_r8_cnt_clears: assert property (@(posedge clk) disable iff (!por_n)
        rst_pin_n |=> (cnt_q == '0));
    a_r6_cnt_bounded: assert property (@(posedge clk) disable iff (!por_n)
        cnt_q <= CNT_TOP);
endmodule

// File: rtl/slumber_fsm.sv
module slumber_fsm
    import slumber_pkg::*;
(
    input  logic clk,
    input  logic por_n,
    input  logic sleep_op,
    input  logic sby_sel,
    input  logic wake,
    input  logic rst_fire,
    input  logic rst_pin_n,
    input  logic sby_pin_n,
    output logic cpu_run,
    output logic irq_exc_go,
    output logic rst_exc_go,
    output logic hw_standby
);
    pm_regs_t r_d, r_q;

    always_comb begin
        r_d        = r_q;
        r_d.irq_go = 1'b0;
        r_d.rst_go = 1'b0;
        if (rst_fire) begin
            r_d.st = PM_RHOLD;
        end else begin
            unique case (r_q.st)
                PM_RUN: begin
                    if (sleep_op && !sby_sel) r_d.st = PM_SLEEP;
                end
                PM_SLEEP: begin
                    if (!sby_pin_n) begin
                        r_d.st = PM_HSTBY;
                    end else if (wake) begin
                        r_d.st     = PM_RUN;
                        r_d.irq_go = 1'b1;
                    end
                end
                PM_RHOLD: begin
                    if (rst_pin_n) begin
                        r_d.st     = PM_RUN;
                        r_d.rst_go = 1'b1;
                    end
                end
                PM_HSTBY: begin
                    r_d.st = PM_HSTBY;
                end
                default: r_d.st = PM_RUN;
            endcase
        end
    end

    always_ff @(posedge clk or negedge por_n) begin
        if (!por_n) begin
            r_q.st     <= PM_RUN;
            r_q.irq_go <= 1'b0;
            r_q.rst_go <= 1'b0;
        end else begin
            r_q <= r_d;
        end
    end

    assign cpu_run    = (r_q.st == PM_RUN);
    assign hw_standby = (r_q.st == PM_HSTBY);
    assign irq_exc_go = r_q.irq_go;
    assign rst_exc_go = r_q.rst_go;

    a_r1_enter_sleep: assert property (@(posedge clk) disable iff (!por_n)
        (cpu_run && sleep_op && !sby_sel && !rst_fire) |=> (!cpu_run && !hw_standby));
    a_r1_sel_blocks: assert property (@(posedge clk) disable iff (!por_n)
        (cpu_run && sby_sel && !rst_fire) |=> cpu_run);
    a_r3_irq_pulse_runs: assert property (@(posedge clk) disable iff (!por_n)
        irq_exc_go |-> (cpu_run && $past(r_q.st == PM_SLEEP)));
    a_r2_stay_asleep: assert property (@(posedge clk) disable iff (!por_n)
        (r_q.st == PM_SLEEP && !wake && sby_pin_n && !rst_fire) |=> (r_q.st == PM_SLEEP));
    a_r5_standby_holds: assert property (@(posedge clk) disable iff (!por_n)
        (hw_standby && !rst_fire) |=> hw_standby);
    a_r9_reset_wins: assert property (@(posedge clk) disable iff (!por_n)
        rst_fire |=> (!cpu_run && !hw_standby && !irq_exc_go));
    a_r7_rst_pulse_runs: assert property (@(posedge clk) disable iff (!por_n)
        rst_exc_go |-> (cpu_run && $past(r_q.st == PM_RHOLD)));
    a_r10_irq_single: assert property (@(posedge clk) disable iff (!por_n)
        irq_exc_go |=> !irq_exc_go);
    a_r10_rst_single: assert property (@(posedge clk) disable iff (!por_n)
        rst_exc_go |=> !rst_exc_go);
endmodule

// File: rtl/slumber_ctrl.sv
module slumber_ctrl #(
    parameter int N_IRQ       = 4,
    parameter int MIN_RST_LOW = 4
) (
    input  logic             clk,
    input  logic             por_n,
    input  logic             sleep_op,
    input  logic             sby_sel,
    input  logic [N_IRQ-1:0] irq_req,
    input  logic [N_IRQ-1:0] irq_en,
    input  logic             mask_all,
    input  logic             nmi,
    input  logic             rst_pin_n,
    input  logic             sby_pin_n,
    output logic             cpu_run,
    output logic             irq_exc_go,
    output logic             rst_exc_go,
    output logic             hw_standby
);
    logic wake;
    logic rst_fire;

    slumber_wake_eval #(.N_IRQ(N_IRQ)) u_wake (
        .irq_req  (irq_req),
        .irq_en   (irq_en),
        .mask_all (mask_all),
        .nmi      (nmi),
        .wake     (wake)
    );

    slumber_rst_qual #(.MIN_RST_LOW(MIN_RST_LOW)) u_rqual (
        .clk       (clk),
        .por_n     (por_n),
        .rst_pin_n (rst_pin_n),
        .rst_fire  (rst_fire)
    );

    slumber_fsm u_fsm (
        .clk        (clk),
        .por_n      (por_n),
        .sleep_op   (sleep_op),
        .sby_sel    (sby_sel),
        .wake       (wake),
        .rst_fire   (rst_fire),
        .rst_pin_n  (rst_pin_n),
        .sby_pin_n  (sby_pin_n),
        .cpu_run    (cpu_run),
        .irq_exc_go (irq_exc_go),
        .rst_exc_go (rst_exc_go),
        .hw_standby (hw_standby)
    );
endmodule

// File: tb/slumber_ctrl_tb.sv
module slumber_ctrl_tb;
    localparam int N_IRQ = 4;
    localparam int MIN_RST_LOW = 4;

    logic clk = 1'b0;
    logic por_n = 1'b0;
    logic sleep_op = 1'b0, sby_sel = 1'b0, mask_all = 1'b0, nmi = 1'b0;
    logic rst_pin_n = 1'b1, sby_pin_n = 1'b1;
    logic [N_IRQ-1:0] irq_req = '0, irq_en = '0;
    logic cpu_run, irq_exc_go, rst_exc_go, hw_standby;

    int n_vec = 0;
    int n_bad = 0;
    bit done = 1'b0;

    typedef struct {
        logic [3:0] outs;
        string      tag;
    } exp_t;
    exp_t sb[$];

    always #5 clk = ~clk;

    slumber_ctrl #(.N_IRQ(N_IRQ), .MIN_RST_LOW(MIN_RST_LOW)) u_dut (
        .clk(clk), .por_n(por_n), .sleep_op(sleep_op), .sby_sel(sby_sel),
        .irq_req(irq_req), .irq_en(irq_en), .mask_all(mask_all), .nmi(nmi),
        .rst_pin_n(rst_pin_n), .sby_pin_n(sby_pin_n),
        .cpu_run(cpu_run), .irq_exc_go(irq_exc_go), .rst_exc_go(rst_exc_go),
        .hw_standby(hw_standby)
    );

    // outs order: {cpu_run, irq_exc_go, rst_exc_go, hw_standby}
    task automatic cyc(input logic [3:0] exp_outs, input string tag);
        exp_t e;
        e.outs = exp_outs;
        e.tag  = tag;
        sb.push_back(e);
        @(posedge clk);
        @(negedge clk);
    endtask

    always @(posedge clk) begin
        #1;
        if (sb.size() > 0) begin
            exp_t e;
            logic [3:0] got;
            e   = sb.pop_front();
            got = {cpu_run, irq_exc_go, rst_exc_go, hw_standby};
            n_vec++;
            if (got !== e.outs) begin
                n_bad++;
                $display("FAIL %s: got %b expected %b", e.tag, got, e.outs);
            end
        end
    end

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
            $finish;
        end
    endtask

    initial begin
        repeat (5000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog: got timeout expected completion");
        finish_run();
    end

    initial begin
        repeat (3) @(negedge clk);
        if ({cpu_run, irq_exc_go, rst_exc_go, hw_standby} !== 4'b1000) begin
            n_bad++;
            $display("FAIL R10 during reset: got %b expected 1000",
                     {cpu_run, irq_exc_go, rst_exc_go, hw_standby});
        end
        n_vec++;
        por_n = 1'b1;
        cyc(4'b1000, "R10 after power-on reset");

        // R1: select bit set blocks sleep
        sleep_op = 1; sby_sel = 1;
        cyc(4'b1000, "R1 strobe with select=1 ignored");
        sleep_op = 0; sby_sel = 0;
        cyc(4'b1000, "R1 still running");
        // R5: standby pin while running ignored
        sby_pin_n = 0;
        cyc(4'b1000, "R5 standby pin in run ignored");
        sby_pin_n = 1;
        // R1 entry
        sleep_op = 1;
        cyc(4'b0000, "R1 sleep entered");
        sleep_op = 0;
        // R2 disabled request
        irq_req = 4'b0001; irq_en = 4'b0000;
        cyc(4'b0000, "R2 disabled request keeps sleep");
        // R4 masked enabled request
        irq_req = 4'b0010; irq_en = 4'b0010; mask_all = 1;
        cyc(4'b0000, "R4 masked request keeps sleep");
        cyc(4'b0000, "R4 still asleep");
        // R4 NMI wakes through mask
        nmi = 1;
        cyc(4'b1100, "R4 nmi wake pulse");
        nmi = 0; irq_req = '0; irq_en = '0; mask_all = 0;
        cyc(4'b1000, "R10 irq pulse one cycle");

        // R3 enabled unmasked request
        sleep_op = 1;
        cyc(4'b0000, "R1 sleep entered again");
        sleep_op = 0;
        irq_req = 4'b0100; irq_en = 4'b0110;
        cyc(4'b1100, "R3 enabled request wakes");
        irq_req = '0; irq_en = '0;
        cyc(4'b1000, "R3 back in run");

        // R5/R9 standby beats interrupt
        sleep_op = 1;
        cyc(4'b0000, "R1 sleep before standby");
        sleep_op = 0;
        sby_pin_n = 0; nmi = 1;
        cyc(4'b0001, "R9 standby beats nmi");
        sby_pin_n = 1;
        cyc(4'b0001, "R5 standby held, pin high");
        cyc(4'b0001, "R5 standby held with nmi");
        nmi = 0;

        // R6 reset from hardware standby
        rst_pin_n = 0;
        for (int k = 1; k < MIN_RST_LOW; k++)
            cyc(4'b0001, "R8 reset not yet qualified");
        cyc(4'b0000, "R6 reset hold entered");
        cyc(4'b0000, "R6 reset hold while low");
        rst_pin_n = 1;
        cyc(4'b1010, "R7 reset exception pulse");
        cyc(4'b1000, "R10 reset pulse one cycle");

        // R8 short pulse in run
        rst_pin_n = 0;
        for (int k = 1; k < MIN_RST_LOW; k++)
            cyc(4'b1000, "R8 short low pulse");
        rst_pin_n = 1;
        cyc(4'b1000, "R8 short pulse ignored");
        cyc(4'b1000, "R8 no reset pulse");

        // R9 reset beats standby and nmi
        sleep_op = 1;
        cyc(4'b0000, "R1 sleep before priority test");
        sleep_op = 0;
        rst_pin_n = 0;
        for (int k = 1; k < MIN_RST_LOW; k++)
            cyc(4'b0000, "R8 sleeping, reset counting");
        sby_pin_n = 0; nmi = 1;
        cyc(4'b0000, "R9 reset beats standby and nmi");
        sby_pin_n = 1; nmi = 0; rst_pin_n = 1;
        cyc(4'b1010, "R7 release after priority test");
        cyc(4'b1000, "R7 running after reset");

        // R6 reset from run during sleep strobe
        rst_pin_n = 0;
        for (int k = 1; k < MIN_RST_LOW; k++)
            cyc(4'b1000, "R6 counting in run");
        sleep_op = 1;
        cyc(4'b0000, "R6 reset beats sleep strobe");
        sleep_op = 0; rst_pin_n = 1;
        cyc(4'b1010, "R7 release from run-side reset");

        while (sb.size() > 0) @(negedge clk);
        @(negedge clk);
        finish_run();
    end
endmodule